// File: doc/BRIEF.md
# Multi-Mode AES Round Engine

This block is an iterative AES-128 datapath that completes one cipher round on every clock edge. The same round hardware runs in four modes. Mission mode encrypts a single 128-bit block in ten rounds. Pattern-generation mode turns the round into a free-running pseudo-random source that emits one 128-bit word per clock. Compaction mode folds one response word from a core under test into the running state on every round. Self-test mode runs the round on its own feedback and shows a signature only when asked to.

Key expansion lives outside the block. An external key generator watches `round_idx` and presents the matching 128-bit round key on `round_key` in the same cycle. In the continuous modes the round index wraps from 10 back to 1, so that generator can keep chaining keys. The host starts a run by pulsing `start` while `ready` is high, with `din` and `mode` valid in that cycle. A start pulse while `ready` is low is dropped. `dout` carries no back-pressure: each `dout_valid` pulse lasts exactly one cycle, and the consumer must take the word in that cycle.

Top module: `aes_round_engine`

## Requirements
- R1: After reset, `dout` is all zeros, `dout_valid` is 0, `round_idx` is 0 and `ready` is 1.
- R2: When `start` is accepted, the state register takes `din` XOR `round_key`, with `round_idx` = 0 presented during that cycle. The mode is sampled in the same cycle, with encoding 0 = mission, 1 = pattern generation, 2 = compaction, 3 = self-test.
- R3: Mission mode runs rounds 1 to 10. Rounds 1 to 9 apply SubBytes, ShiftRows, MixColumns and AddRoundKey in that order; round 10 omits MixColumns. On the tenth round edge, `dout` is loaded with the ciphertext, `dout_valid` pulses for one cycle and the engine returns to idle. State byte j sits at bits [127-8j -: 8], column-major as in the standard.
- R4: `round_idx` is 0 while idle and equals k while round k is being computed. It never exceeds 10.
- R5: In pattern-generation mode, every round loads `dout` with that round's result and pulses `dout_valid`, giving one word per clock. The index wraps from 10 to 1, and each wrapped round 10 omits MixColumns.
- R6: In compaction mode, each round's input is the state XOR `resp`. `dout` is loaded only in a cycle where `obs_en` or `halt` is high.
- R7: Self-test mode runs the round on the unmodified state with the same wrap as R5. `dout` is loaded only in a cycle where `obs_en` or `halt` is high.
- R8: In the three continuous modes, `halt` lets the current round finish, loads `dout` with its result and returns the engine to idle. In mission mode `halt` has no effect.
- R9: A `start` pulse while busy is ignored, including its mode and data.
- R10: Outside a load cycle, `dout_valid` is 0 and `dout` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request; `din` and `mode` are valid with it |
| ready | output | 1 | High when idle; `start` is accepted only then |
| mode | input | 2 | 0 mission, 1 pattern generation, 2 compaction, 3 self-test |
| halt | input | 1 | Ends a continuous run after the current round |
| obs_en | input | 1 | Loads the intermediate signature in compaction and self-test modes |
| din | input | 128 | Plaintext or seed |
| resp | input | 128 | Response word from the core under test |
| round_key | input | 128 | Round key for the index on `round_idx` |
| round_idx | output | 4 | Round number the key generator must serve |
| dout | output | 128 | Output register |
| dout_valid | output | 1 | One-cycle pulse when `dout` is loaded |

## Verification
The assertions assume that `round_key` always belongs to the index shown on `round_idx` in the same cycle. The bench meets this by deriving the key combinationally from a precomputed key schedule indexed by that output. They also assume that `mode` carries meaning only in the cycle where `start` meets `ready`. For that reason the stimulus deliberately changes `mode`, raises `start` and toggles `halt` in the middle of runs, so that only the sampled values can matter. Every other input changes only on falling edges, so each value is stable at the rising edge that samples it.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;
  localparam int unsigned BLK_W = 128;
  localparam int unsigned NBYTE = BLK_W / 8;
  localparam int unsigned RND_W = 4;

  typedef enum logic [1:0] {
    MODE_MISSION  = 2'd0,
    MODE_PATGEN   = 2'd1,
    MODE_COMPACT  = 2'd2,
    MODE_SELFTEST = 2'd3
  } eng_mode_e;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254 (bits 1..7 of the exponent set); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    r = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_calc(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] a,
  output logic [7:0] y
);
  import aes_eng_pkg::*;
  // full 256-point substitution, evaluated as a combinational table
  always_comb y = sbox_calc(a);
endmodule

// File: rtl/aes_round.sv
module aes_round #(
  parameter int unsigned NB = 16
) (
  input  logic [8*NB-1:0] st_in,
  input  logic [8*NB-1:0] rkey,
  input  logic            skip_mix,
  output logic [8*NB-1:0] st_out
);
  import aes_eng_pkg::*;
  localparam int unsigned W    = 8 * NB;
  localparam int unsigned NCOL = NB / 4;

  logic [7:0] sb [NB];
  logic [7:0] sr [NB];
  logic [7:0] mc [NB];

  for (genvar i = 0; i < NB; i++) begin : g_sub
    aes_sbox u_sbox (.a(st_in[W-1-8*i -: 8]), .y(sb[i]));
  end

  for (genvar i = 0; i < NB; i++) begin : g_shift
    localparam int unsigned ROW = i % 4;
    localparam int unsigned COL = i / 4;
    localparam int unsigned SRC = 4 * ((COL + ROW) % NCOL) + ROW;
    assign sr[i] = sb[SRC];
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_mix
    logic [7:0] b0, b1, b2, b3;
    assign b0 = sr[4*c];
    assign b1 = sr[4*c+1];
    assign b2 = sr[4*c+2];
    assign b3 = sr[4*c+3];
    assign mc[4*c]   = xtime(b0) ^ xtime(b1) ^ b1 ^ b2 ^ b3;
    assign mc[4*c+1] = b0 ^ xtime(b1) ^ xtime(b2) ^ b2 ^ b3;
    assign mc[4*c+2] = b0 ^ b1 ^ xtime(b2) ^ xtime(b3) ^ b3;
    assign mc[4*c+3] = xtime(b0) ^ b0 ^ b1 ^ b2 ^ xtime(b3);
  end

  for (genvar i = 0; i < NB; i++) begin : g_ark
    assign st_out[W-1-8*i -: 8] = (skip_mix ? sr[i] : mc[i]) ^ rkey[W-1-8*i -: 8];
  end
endmodule

// File: rtl/aes_eng_ctrl.sv
module aes_eng_ctrl #(
  parameter int unsigned ROUNDS = 10,
  parameter int unsigned RW     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode_in,
  input  logic                  halt,
  input  logic                  obs_en,
  output logic                  busy,
  output logic                  accept,
  output aes_eng_pkg::eng_mode_e mode_q,
  output logic [RW-1:0]         rnd,
  output logic                  last_round,
  output logic                  fold_resp,
  output logic                  load_out
);
  import aes_eng_pkg::*;
  localparam logic [RW-1:0] LAST = RW'(ROUNDS);

  logic finish;
  logic is_mission;
  logic observe;

  assign accept     = start & ~busy;
  assign is_mission = (mode_q == MODE_MISSION);
  assign last_round = busy & (rnd == LAST);
  assign fold_resp  = busy & (mode_q == MODE_COMPACT);
  assign finish     = busy & (is_mission ? last_round : halt);
  assign observe    = (mode_q == MODE_COMPACT) | (mode_q == MODE_SELFTEST);

  always_comb begin
    load_out = 1'b0;
    if (busy) begin
      unique case (mode_q)
        MODE_MISSION:  load_out = last_round;
        MODE_PATGEN:   load_out = 1'b1;
        default:       load_out = observe & (obs_en | halt);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= MODE_MISSION;
      rnd    <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      mode_q <= eng_mode_e'(mode_in);
      rnd    <= RW'(1);
    end else if (busy) begin
      if (finish) begin
        busy <= 1'b0;
        rnd  <= '0;
      end else if (last_round) begin
        rnd <= RW'(1);
      end else begin
        rnd <= rnd + RW'(1);
      end
    end
  end

  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rnd <= LAST);
  p_idle_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rnd == '0);
  p_mission_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_mission && rnd == LAST) |=> !busy);
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_mission && rnd == LAST && !halt) |=> (busy && rnd == RW'(1)));
  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
  p_halt_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_mission && halt) |=> !busy);
endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine #(
  parameter int unsigned ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         ready,
  input  logic [1:0]   mode,
  input  logic         halt,
  input  logic         obs_en,
  input  logic [127:0] din,
  input  logic [127:0] resp,
  input  logic [127:0] round_key,
  output logic [3:0]   round_idx,
  output logic [127:0] dout,
  output logic         dout_valid
);
  import aes_eng_pkg::*;
  localparam int unsigned W = BLK_W;

  logic         busy, accept, last_round, fold_resp, load_out;
  eng_mode_e    mode_q;
  logic [RND_W-1:0] rnd;
  logic [W-1:0] st_q, rin, rout;

  aes_eng_ctrl #(.ROUNDS(ROUNDS), .RW(RND_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode), .halt(halt),
    .obs_en(obs_en), .busy(busy), .accept(accept), .mode_q(mode_q), .rnd(rnd),
    .last_round(last_round), .fold_resp(fold_resp), .load_out(load_out)
  );

  assign rin = fold_resp ? (st_q ^ resp) : st_q;

  aes_round #(.NB(NBYTE)) u_round (
    .st_in(rin), .rkey(round_key), .skip_mix(last_round), .st_out(rout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      if (accept)    st_q <= din ^ round_key;
      else if (busy) st_q <= rout;
      dout_valid <= load_out;
      if (load_out) dout <= rout;
    end
  end

  assign ready     = ~busy;
  assign round_idx = rnd;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> $stable(dout));
  p_patgen_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_PATGEN) |=> dout_valid);
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));
endmodule

// File: tb/test_aes_round_engine.sv
`timescale 1ns/1ps
module test_aes_round_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         ready;
  logic [1:0]   mode = 2'd0;
  logic         halt = 1'b0;
  logic         obs_en = 1'b0;
  logic [127:0] din = '0;
  logic [127:0] resp = '0;
  logic [127:0] round_key;
  logic [3:0]   round_idx;
  logic [127:0] dout;
  logic         dout_valid;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aes_round_engine i_aes_round_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .mode(mode),
    .halt(halt), .obs_en(obs_en), .din(din), .resp(resp), .round_key(round_key),
    .round_idx(round_idx), .dout(dout), .dout_valid(dout_valid)
  );

  logic [7:0]   sbt [256];
  logic [127:0] ks  [11];

  assign round_key = (round_idx <= 4'd10) ? ks[round_idx] : '0;

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    while (bb != 0) begin
      if (bb[0]) r ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return r;
  endfunction

  task automatic build_tables(input logic [127:0] key);
    logic [7:0] inv, s;
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int x = 0; x < 256; x++) begin
      inv = 0;
      for (int y = 1; y < 256; y++) if (gm(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
      for (int b = 0; b < 8; b++)
        s[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 1);
      sbt[x] = s;
    end
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sbt[t[23:16]], sbt[t[15:8]], sbt[t[7:0]], sbt[t[31:24]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k, input bit mix);
    logic [7:0] a [16];
    logic [7:0] b [16];
    logic [7:0] t0, t1, t2, t3;
    logic [127:0] o;
    for (int j = 0; j < 16; j++) a[j] = sbt[s[127-8*j -: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) b[4*c+r] = a[4*((c+r)%4)+r];
    if (mix) begin
      for (int c = 0; c < 4; c++) begin
        t0 = b[4*c]; t1 = b[4*c+1]; t2 = b[4*c+2]; t3 = b[4*c+3];
        b[4*c]   = gm(2,t0) ^ gm(3,t1) ^ t2 ^ t3;
        b[4*c+1] = t0 ^ gm(2,t1) ^ gm(3,t2) ^ t3;
        b[4*c+2] = t0 ^ t1 ^ gm(2,t2) ^ gm(3,t3);
        b[4*c+3] = gm(3,t0) ^ t1 ^ t2 ^ gm(2,t3);
      end
    end
    for (int j = 0; j < 16; j++) o[127-8*j -: 8] = b[j] ^ k[127-8*j -: 8];
    return o;
  endfunction

  // behavioural reference
  bit           m_busy = 0;
  int           m_mode = 0;
  int           m_rnd = 0;
  logic [127:0] m_st = '0;
  logic [127:0] m_dout = '0;
  bit           m_valid = 0;

  task automatic model_step();
    logic [127:0] in, res;
    bit last, load;
    if (!m_busy && start) begin
      m_busy = 1; m_mode = int'(mode); m_st = din ^ ks[0]; m_rnd = 1; m_valid = 0;
    end else if (m_busy) begin
      in = (m_mode == 2) ? (m_st ^ resp) : m_st;
      last = (m_rnd == 10);
      res = ref_round(in, ks[m_rnd], !last);
      load = (m_mode == 0 && last) || m_mode == 1 || (m_mode >= 2 && (obs_en || halt));
      m_valid = load;
      if (load) m_dout = res;
      m_st = res;
      if ((m_mode == 0 && last) || (m_mode != 0 && halt)) begin
        m_busy = 0; m_rnd = 0;
      end else m_rnd = last ? 1 : m_rnd + 1;
    end else m_valid = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    string dreq;
    case (m_mode)
      0: dreq = "R3";
      1: dreq = "R5";
      2: dreq = "R6";
      default: dreq = "R7";
    endcase
    check(dout === m_dout, dreq, "dout", dout, m_dout);
    check(dout_valid === m_valid, "R10", "dout_valid", 128'(dout_valid), 128'(m_valid));
    check(round_idx === 4'(m_rnd), "R4", "round_idx", 128'(round_idx), 128'(m_rnd));
    check(ready === !m_busy, "R9", "ready", 128'(ready), 128'(!m_busy));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run_start(input logic [1:0] md, input logic [127:0] d);
    mode = md; din = d; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL R9 watchdog: actual %0d cycles expected under 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] ct;
    bit seen;
    build_tables(128'h000102030405060708090a0b0c0d0e0f);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout === '0 && dout_valid === 1'b0, "R1", "reset dout/valid", dout, '0);
    check(round_idx === 4'd0 && ready === 1'b1, "R1", "reset idx/ready", 128'(round_idx), 0);

    // mission, standard vector, with a busy start and a halt that must be ignored
    run_start(2'd0, 128'h00112233445566778899aabbccddeeff);
    seen = 0; ct = '0;
    for (int i = 0; i < 12; i++) begin
      start = (i == 3); mode = 2'd1; din = '1;
      halt = (i == 5);
      tick();
      if (dout_valid) begin seen = 1; ct = dout; end
    end
    start = 0; halt = 0;
    check(seen, "R8", "mission completes despite halt", 128'(seen), 1);
    check(ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3", "ciphertext", ct,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2", "whitening before round 1", ct,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // pattern generation across two wraps
    run_start(2'd1, 128'hdeadbeef0123456789abcdeffedcba98);
    for (int i = 0; i < 24; i++) tick();
    halt = 1; tick(); halt = 0;
    check(round_idx === 4'd0 && ready === 1'b1, "R8", "idle after halt", 128'(round_idx), 0);
    tick();

    // compaction with changing responses and some observation cycles
    run_start(2'd2, '0);
    resp = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    for (int i = 0; i < 23; i++) begin
      resp = {resp[126:0], resp[127] ^ resp[93] ^ resp[40]} ^ 128'(i);
      obs_en = (i % 7 == 3);
      tick();
    end
    obs_en = 0; halt = 1; tick(); halt = 0;
    check(dout_valid === 1'b1, "R6", "final signature loaded", 128'(dout_valid), 1);
    tick();

    // self-test, one observation then halt
    run_start(2'd3, 128'h13579bdf2468ace0fedcba9876543210);
    for (int i = 0; i < 30; i++) begin
      obs_en = (i == 14);
      tick();
    end
    obs_en = 0; halt = 1; tick(); halt = 0;
    check(dout_valid === 1'b1, "R7", "signature on halt", 128'(dout_valid), 1);

    // second mission with different data
    run_start(2'd0, 128'hffeeddccbbaa99887766554433221100);
    for (int i = 0; i < 12; i++) tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule